// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a simple single-access request port inside the chip and an external asynchronous static RAM holding 8,192 words of 9 bits. The RAM has no clock of its own. It is selected by a pair of enables of opposite polarity, is read when its output enable is active and its write strobe is inactive, and stores a word whenever both selects and the active-low write strobe are active together. The controller turns each request into a pin sequence of whole clock cycles. Every phase length is a nanosecond minimum rounded up to a number of clock periods.

A client raises `req_valid` for one cycle with the address, direction and write word. The request is accepted only while the controller is idle. The controller latches the address and holds it on the memory pins for the whole access. For a read it keeps both selects and the output enable active until the access-time budget has elapsed. It then registers the returned word. For a write it drives the strobe low for the write-pulse budget. It drives the data lines only from the cycle after the strobe falls until the cycle after the strobe rises, so the write is ended by the strobe while data is still on the bus. Each completed access is reported by a one-cycle `done` pulse. That pulse comes in a cycle in which every memory enable is inactive.

The data bus is given as three separate ports: outgoing data, drive enable and incoming data. Pad logic outside the block joins them into one bidirectional bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request: `mem_en_lo_n`=1, `mem_en_hi`=0, `mem_out_en_n`=1, `mem_wr_n`=1, `mem_dq_oe`=0, `busy`=0, `done`=0.
- R2: A read request (`req_write`=0) makes the controller hold `mem_en_lo_n`=0, `mem_en_hi`=1, `mem_out_en_n`=0, `mem_wr_n`=1 and `mem_addr` equal to the request address for exactly RD_CYC consecutive cycles, starting the cycle after acceptance. `mem_dq_oe` stays 0 throughout.
- R3: The read word is sampled from `mem_dq_i` on the last of the RD_CYC read cycles. It appears on `rd_data` in the cycle `done` is high, which is RD_CYC+1 cycles after the accepting edge.
- R4: A write request makes the controller hold `mem_en_lo_n`=0, `mem_en_hi`=1, `mem_out_en_n`=1 and `mem_wr_n`=0 for exactly WE_CYC consecutive cycles. One further cycle follows with both selects still active and `mem_wr_n`=1. `done` follows WE_CYC+2 cycles after the accepting edge.
- R5: `mem_dq_oe` is high exactly in the cycles after a cycle in which `mem_wr_n` was low. These are the last WE_CYC-1 strobe cycles plus the one cycle after the strobe rises. In those cycles `mem_dq_o` carries the write word. It is never high while `mem_out_en_n` is low.
- R6: `mem_addr` does not change while `mem_en_lo_n` stays low.
- R7: Each access gives exactly one `done` pulse of one cycle. In that cycle all memory enables are inactive and the bus is released. `busy` falls the cycle after.
- R8: A request raised while `busy` is high is ignored. It gives no extra access, no extra `done` and no change to memory.
- R9: Phase counts are ceil(ns / CLK_PERIOD_NS), each at least 1. RD_CYC is the largest of the counts for cycle time, address access time and output-enable access time. WE_CYC is the largest of the counts for the strobe pulse and the cycle time, and of the data-setup count plus one. At 8 ns these give RD_CYC=4 and WE_CYC=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 9 | Word to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 9 | Last word read |
| mem_addr | output | 13 | Address pins of the memory |
| mem_en_lo_n | output | 1 | Active-low chip select |
| mem_en_hi | output | 1 | Active-high chip select |
| mem_out_en_n | output | 1 | Active-low output enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_dq_o | output | 9 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 9 | Data returned from the pads |

## Verification
The access path is exercised with words of all ones, all zeros and alternating bits, at the lowest, highest and patterned addresses. Stuck or swapped data and address lines therefore give a wrong word on read-back. An overwrite of an address that was already written shows that a stale value cannot pass. The bench's memory model returns valid data only after the access time has elapsed, so a read phase that is too short brings back a filler pattern. The model also stores a word only at the rising edge of the write strobe and only while data is being driven, so a strobe that ends after the bus is released, or any overlap with the read drivers, is caught. A request placed during a write shows whether requests are held off while busy: the target address is then read back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_GAP    = 3'd4
  } ctrl_state_e;

  // Round a nanosecond minimum up to whole clock periods, never below one.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load) begin
      cnt_nxt = load_len - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  assign expired = (cnt_q == '0);

  // R9: a loaded length of one or more never wraps below zero
  a_r9_no_underflow : assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  ctrl_state_e state,
  output logic        en_lo_n,
  output logic        en_hi,
  output logic        out_en_n,
  output logic        wr_n
);

  always_comb begin
    en_lo_n  = 1'b1;
    en_hi    = 1'b0;
    out_en_n = 1'b1;
    wr_n     = 1'b1;
    unique case (state)
      ST_READ: begin
        en_lo_n  = 1'b0;
        en_hi    = 1'b1;
        out_en_n = 1'b0;
      end
      ST_WPULSE: begin
        en_lo_n = 1'b0;
        en_hi   = 1'b1;
        wr_n    = 1'b0;
      end
      ST_WHOLD: begin
        en_lo_n = 1'b0;
        en_hi   = 1'b1;
      end
      default: begin
        en_lo_n  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic              load_wdata,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              rd_capture,
  input  logic              drive_nxt,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_addr) begin
      addr_q <= addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (load_wdata) begin
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_capture) begin
      rd_q <= dq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
    end else begin
      oe_q <= drive_nxt;
    end
  end

  assign mem_addr = addr_q;
  assign dq_o     = wdata_q;
  assign dq_oe    = oe_q;
  assign rd_data  = rd_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 9,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_CYCLE_NS    = 25,
  parameter int T_ADDR_ACC_NS = 25,
  parameter int T_OE_ACC_NS   = 15,
  parameter int T_WR_PULSE_NS = 20,
  parameter int T_WR_SETUP_NS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_lo_n,
  output logic              mem_en_hi,
  output logic              mem_out_en_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_CYC = max_of3(ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_OE_ACC_NS, CLK_PERIOD_NS));
  localparam int WE_CYC = max_of3(ns_to_cycles(T_WR_PULSE_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_WR_SETUP_NS, CLK_PERIOD_NS) + 1);
  localparam int MAX_CYC = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e      state_q;
  ctrl_state_e      state_nxt;
  logic             done_q;
  logic             done_nxt;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_expired;
  logic             rd_capture;

  assign accept = req_valid && (state_q == ST_IDLE);

  // Next-state logic
  always_comb begin
    state_nxt  = state_q;
    tmr_load   = 1'b0;
    tmr_len    = CNT_W'(RD_CYC);
    rd_capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tmr_load  = 1'b1;
          state_nxt = req_write ? ST_WPULSE : ST_READ;
          tmr_len   = req_write ? CNT_W'(WE_CYC) : CNT_W'(RD_CYC);
        end
      end
      ST_READ: begin
        if (tmr_expired) begin
          rd_capture = 1'b1;
          state_nxt  = ST_GAP;
        end
      end
      ST_WPULSE: begin
        if (tmr_expired) state_nxt = ST_WHOLD;
      end
      ST_WHOLD:  state_nxt = ST_GAP;
      ST_GAP:    state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
    done_nxt = (state_nxt == ST_GAP);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      done_q  <= done_nxt;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .expired  (tmr_expired)
  );

  sram_pin_decode u_pins (
    .state    (state_q),
    .en_lo_n  (mem_en_lo_n),
    .en_hi    (mem_en_hi),
    .out_en_n (mem_out_en_n),
    .wr_n     (mem_wr_n)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_addr  (accept),
    .load_wdata (accept && req_write),
    .addr_in    (req_addr),
    .wdata_in   (req_wdata),
    .rd_capture (rd_capture),
    .drive_nxt  (state_q == ST_WPULSE),
    .dq_i       (mem_dq_i),
    .mem_addr   (mem_addr),
    .dq_o       (mem_dq_o),
    .dq_oe      (mem_dq_oe),
    .rd_data    (rd_data)
  );

  // R5: never drive against the memory's own output drivers
  a_r5_no_drive_on_read : assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_out_en_n);

  // R5: drive starts only after the strobe has been low for a cycle
  a_r5_drive_after_strobe : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(!mem_wr_n));

  // R4: the strobe is low only while both selects are active
  a_r4_strobe_selected : assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_en_lo_n && mem_en_hi));

  // R2: output enable and strobe are never active together
  a_r2_oe_strobe_apart : assert property (@(posedge clk) disable iff (!rst_n)
    !mem_out_en_n |-> mem_wr_n);

  // R6: address frozen while selected
  a_r6_addr_stable : assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_lo_n && $past(!mem_en_lo_n)) |-> $stable(mem_addr));

  // R7: completion is a single cycle, with the memory fully deselected
  a_r7_done_single : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle_pins : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_en_lo_n && !mem_en_hi && mem_out_en_n && mem_wr_n && !mem_dq_oe));

  // R8: a request while busy loads nothing
  a_r8_busy_holdoff : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(mem_addr));

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

  localparam int PER     = 8;
  localparam int NVEC    = 12;
  localparam logic [8:0] FILLER = 9'h0AA ^ 9'h1C3;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_RD = imax(imax(cyc(25), cyc(25)), cyc(15));
  localparam int EXP_WE = imax(imax(cyc(20), cyc(25)), cyc(15) + 1);

  // {write, address, data}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 13'h0000, 9'h1FF},
    {1'b1, 13'h1FFF, 9'h000},
    {1'b1, 13'h0AAA, 9'h0AA},
    {1'b1, 13'h1555, 9'h155},
    {1'b0, 13'h0000, 9'h000},
    {1'b0, 13'h1FFF, 9'h000},
    {1'b0, 13'h0AAA, 9'h000},
    {1'b0, 13'h1555, 9'h000},
    {1'b1, 13'h0000, 9'h0F0},
    {1'b0, 13'h0000, 9'h000},
    {1'b1, 13'h1234, 9'h10F},
    {1'b0, 13'h1234, 9'h000}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [12:0] req_addr;
  logic [8:0]  req_wdata;
  logic        busy;
  logic        done;
  logic [8:0]  rd_data;
  logic [12:0] mem_addr;
  logic        mem_en_lo_n;
  logic        mem_en_hi;
  logic        mem_out_en_n;
  logic        mem_wr_n;
  logic [8:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [8:0]  mem_dq_i;

  int n_chk;
  int n_fail;

  sram_async_ctrl u_sram_async_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .busy         (busy),
    .done         (done),
    .rd_data      (rd_data),
    .mem_addr     (mem_addr),
    .mem_en_lo_n  (mem_en_lo_n),
    .mem_en_hi    (mem_en_hi),
    .mem_out_en_n (mem_out_en_n),
    .mem_wr_n     (mem_wr_n),
    .mem_dq_o     (mem_dq_o),
    .mem_dq_oe    (mem_dq_oe),
    .mem_dq_i     (mem_dq_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- memory model (sampled away from the active edge) ----
  logic [8:0] model_mem [int];
  int  rd_cnt;
  int  wr_drv_cnt;
  bit  prev_wr_low;
  int  contention_cnt;
  int  nodrive_cnt;
  int  short_setup_cnt;

  initial begin
    rd_cnt = 0; wr_drv_cnt = 0; prev_wr_low = 1'b0;
    contention_cnt = 0; nodrive_cnt = 0; short_setup_cnt = 0;
    mem_dq_i = FILLER;
  end

  always @(negedge clk) begin
    bit rd_act;
    bit sel;
    sel    = !mem_en_lo_n && mem_en_hi;
    rd_act = sel && !mem_out_en_n && mem_wr_n;
    if (rd_act) rd_cnt = rd_cnt + 1; else rd_cnt = 0;
    if (rd_act && rd_cnt * PER >= 25)
      mem_dq_i <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 9'h000;
    else
      mem_dq_i <= FILLER;
    if (mem_dq_oe && rd_act) contention_cnt = contention_cnt + 1;
    if (sel && !mem_wr_n && mem_dq_oe) wr_drv_cnt = wr_drv_cnt + 1;
    if (prev_wr_low && mem_wr_n) begin
      if (!mem_dq_oe) nodrive_cnt = nodrive_cnt + 1;
      if (wr_drv_cnt * PER < 15) short_setup_cnt = short_setup_cnt + 1;
      model_mem[int'(mem_addr)] = mem_dq_o;
      wr_drv_cnt = 0;
    end
    prev_wr_low = sel && !mem_wr_n;
  end

  // ---------------- checking helpers ------------------------------------
  logic [8:0] shadow [int];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_access(input bit wr, input logic [12:0] a, input logic [8:0] d,
                            output logic [8:0] got);
    int  n;
    int  we_low;
    int  drv;
    bit  pins_ok;
    bit  drv_ok;
    bit  last_wr_low;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; we_low = 0; drv = 0; pins_ok = 1'b1; drv_ok = 1'b1; last_wr_low = 1'b0;
    while (!done && n < 40) begin
      if (mem_en_lo_n || !mem_en_hi || mem_addr != a) pins_ok = 1'b0;
      if (!wr && (mem_out_en_n || !mem_wr_n || mem_dq_oe)) pins_ok = 1'b0;
      if (wr && !mem_out_en_n) pins_ok = 1'b0;
      if (!mem_wr_n) we_low = we_low + 1;
      if (mem_dq_oe) begin
        drv = drv + 1;
        if (mem_dq_o != d) drv_ok = 1'b0;
      end
      if (mem_dq_oe != last_wr_low) drv_ok = 1'b0;
      last_wr_low = !mem_wr_n;
      @(negedge clk);
      n = n + 1;
    end
    got = rd_data;
    if (wr) begin
      check(n == EXP_WE + 2, "R4/R9 write latency", n, EXP_WE + 2);
      check(pins_ok && we_low == EXP_WE, "R4 write pins/strobe width", we_low, EXP_WE);
      check(drv_ok && drv == EXP_WE, "R5 data drive window", drv, EXP_WE);
      shadow[int'(a)] = d;
    end else begin
      check(n == EXP_RD + 1, "R2/R9 read latency", n, EXP_RD + 1);
      check(pins_ok, "R2 read pins held", int'(pins_ok), 1);
      check(got == shadow[int'(a)], "R3 read data", got, shadow[int'(a)]);
    end
    check(mem_en_lo_n && !mem_en_hi && mem_out_en_n && mem_wr_n && !mem_dq_oe,
          "R7 pins idle during done", int'(mem_en_hi), 0);
    @(negedge clk);
    check(!done && !busy, "R7 single done then idle", int'(done), 0);
  endtask

  // ---------------- watchdog --------------------------------------------
  initial begin
    repeat (200000) @(posedge clk);
    n_chk = n_chk + 1;
    n_fail = n_fail + 1;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  // ---------------- main sequence ---------------------------------------
  initial begin
    logic [8:0] got;
    int dones;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(mem_en_lo_n && !mem_en_hi && mem_out_en_n && mem_wr_n,
          "R1 enables inactive in reset", {mem_en_lo_n, mem_en_hi, mem_out_en_n, mem_wr_n}, 4'b1011);
    check(!mem_dq_oe && !busy && !done, "R1 bus released, idle", {mem_dq_oe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_en_lo_n && !mem_en_hi && !mem_dq_oe && !busy, "R1 idle after reset",
          {mem_en_lo_n, mem_en_hi, mem_dq_oe, busy}, 4'b1000);

    // Vector table: writes, read-backs, overwrite
    for (int i = 0; i < NVEC; i++) begin
      run_access(VEC[i][22], VEC[i][21:9], VEC[i][8:0], got);
    end

    // R8: request during a write is ignored
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0155; req_wdata = 9'h123;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0AAA; req_wdata = 9'h0F0;
    @(negedge clk);
    req_valid = 1'b0;
    dones = 0;
    for (int k = 0; k < 16; k++) begin
      if (done) dones = dones + 1;
      @(negedge clk);
    end
    check(dones == 1, "R8 one done for held-off request", dones, 1);
    check(!busy, "R8 no extra access started", int'(busy), 0);
    shadow[int'(13'h0155)] = 9'h123;
    run_access(1'b0, 13'h0AAA, 9'h000, got);
    check(got == 9'h0AA, "R8 held-off write left memory unchanged", got, 9'h0AA);
    run_access(1'b0, 13'h0155, 9'h000, got);

    // R5: memory-model observations over the whole run
    check(contention_cnt == 0, "R5 no bus contention", contention_cnt, 0);
    check(nodrive_cnt == 0, "R5 data driven at strobe rise", nodrive_cnt, 0);
    check(short_setup_cnt == 0, "R5 data setup before strobe rise", short_setup_cnt, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule